// File: doc/BRIEF.md
# T1/E1 Transmit Line Encoder

This block turns transmit data from the system side into per-bit pulse requests for a bipolar line driver. Each bit period is marked by a one-cycle `bit_en` strobe. On each strobe the block takes one input bit and issues one output symbol on two registered pins, `tip_pulse` and `ring_pulse`. The tip pin means a positive pulse and the ring pin means a negative pulse. When neither pin is high, the line carries a null for that period.

In single-rail mode the NRZ bit stream is coded as alternate mark inversion. Zero substitution can be switched on. At the 1.544 Mb/s rate, runs of eight zeros are replaced by the pattern 000VB0VB. At the 2.048 Mb/s rate, runs of four zeros are replaced by 000V or B00V, following the HDB3 parity rule. In dual-rail mode the system supplies the two polarities itself, and the block only delays them. A look-ahead window of symbols gives each configuration a fixed latency: eight bit periods for the eight-zero code, four for the four-zero code, and `AMI_DEPTH` (three by default) for plain coding and for dual-rail mode.

The line is paced by the transmit clock enable, and there is no back-pressure. Every strobe consumes one input bit and produces one output symbol. Between strobes the input pins are not sampled and the outputs hold. The configuration pins are expected to change only while reset is asserted.

Top module: `t1e1_tx_encoder`

## Requirements
- R1: In single-rail mode with substitution off, each input 1 yields a pulse. Successive pulses alternate polarity, and the first pulse after reset is on `tip_pulse`.
- R2: `tip_pulse` and `ring_pulse` are never high together. An input 0 with no substitution yields a null, meaning both pins are low.
- R3: With `zs_en`=1 and `rate_cept`=0, every run of eight consecutive input zeros is sent as 0,0,0,V,B,0,V,B. V repeats the polarity of the previous pulse, and B takes the opposite polarity of the previous pulse.
- R4: With `zs_en`=1 and `rate_cept`=1, every run of four zeros is sent as 0,0,0,V when an odd number of B pulses has gone out since the last V. Otherwise it is sent as B,0,0,V. The count is even after reset, and successive V pulses alternate in polarity.
- R5: The symbol for the bit sampled at strobe k appears at strobe k+L. L is 8 for the eight-zero code, 4 for the four-zero code, and `AMI_DEPTH` otherwise. The first L strobes after reset give nulls, and a zero run only counts bits taken after reset.
- R6: In dual-rail mode (`dual_rail`=1), `pos_data` alone gives a tip pulse, `neg_data` alone gives a ring pulse, and both or neither give a null. No coding is applied, whatever the values of `zs_en` and `rate_cept`.
- R7: The outputs change only on cycles where `bit_en` is high. Input changes between strobes have no effect.
- R8: Synchronous reset drives both outputs low, empties the window, resets the HDB3 count to even, and makes the next pulse positive.
- R9: With `zs_en`=0, zero runs of any length go out as nulls, at either rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per bit period |
| dual_rail | input | 1 | 0: single NRZ stream, 1: separate polarity rails |
| zs_en | input | 1 | Enable zero substitution (single-rail only) |
| rate_cept | input | 1 | 0: 1.544 Mb/s eight-zero code, 1: 2.048 Mb/s four-zero code |
| nrz_data | input | 1 | Single-rail data bit |
| pos_data | input | 1 | Dual-rail positive bit |
| neg_data | input | 1 | Dual-rail negative bit |
| tip_pulse | output | 1 | Positive pulse request |
| ring_pulse | output | 1 | Negative pulse request |

## Verification
The assertions assume that `dual_rail`, `zs_en` and `rate_cept` stay fixed outside reset. The polarity-alternation checks for plain coding and for HDB3 violations only mean something within a single configuration. The bench honours this by changing the configuration only while `rst` is held. It always reasserts reset before the next stream. Between strobes the bench deliberately changes the data pins, to exercise the hold rule. It never pulses `bit_en` on consecutive cycles in a way that would break the one-bit-per-strobe pacing.

// File: rtl/t1e1_tx_pkg.sv
package t1e1_tx_pkg;

  typedef enum logic [2:0] {
    SYM_SPACE   = 3'd0,
    SYM_MARK    = 3'd1,
    SYM_VIOL    = 3'd2,
    SYM_FIX_POS = 3'd3,
    SYM_FIX_NEG = 3'd4
  } sym_e;

  typedef enum logic [1:0] {
    CODE_AMI  = 2'd0,
    CODE_B8ZS = 2'd1,
    CODE_HDB3 = 2'd2,
    CODE_DUAL = 2'd3
  } code_e;

  // Protocol run lengths (fixed by the line codes)
  localparam int B8ZS_RUN = 8;
  localparam int HDB3_RUN = 4;

  function automatic code_e pick_code(input logic dual, input logic zs, input logic cept);
    if (dual)      return CODE_DUAL;
    else if (!zs)  return CODE_AMI;
    else if (cept) return CODE_HDB3;
    else           return CODE_B8ZS;
  endfunction

  // Eight-zero replacement, slot 0 is the newest bit: oldest-first 000VB0VB
  function automatic sym_e b8zs_slot(input int j);
    if (j == 4 || j == 1)      return SYM_VIOL;
    else if (j == 3 || j == 0) return SYM_MARK;
    else                       return SYM_SPACE;
  endfunction

endpackage

// File: rtl/t1e1_sym_map.sv
module t1e1_sym_map
  import t1e1_tx_pkg::*;
(
  input  logic dual_rail,
  input  logic nrz_data,
  input  logic pos_data,
  input  logic neg_data,
  output sym_e sym
);

  always_comb begin
    if (!dual_rail) begin
      sym = nrz_data ? SYM_MARK : SYM_SPACE;
    end else begin
      unique case ({pos_data, neg_data})
        2'b10:   sym = SYM_FIX_POS;
        2'b01:   sym = SYM_FIX_NEG;
        default: sym = SYM_SPACE;   // both or neither rail: null
      endcase
    end
  end

endmodule

// File: rtl/t1e1_zs_window.sv
module t1e1_zs_window
  import t1e1_tx_pkg::*;
#(
  parameter int MAX_D     = 8,
  parameter int AMI_DEPTH = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_en,
  input  code_e code,
  input  sym_e  sym_in,
  input  logic  hdb3_odd,
  output sym_e  sym_out
);

  localparam int IDX_W = $clog2(MAX_D + 1);

  sym_e             win  [MAX_D];
  sym_e             cand [MAX_D];
  sym_e             nxt  [MAX_D];
  logic [IDX_W-1:0] depth;
  logic [IDX_W-1:0] fill;
  logic             run_zero;
  logic             run_real;
  logic             sub_b8;
  logic             sub_hd;

  always_comb begin
    unique case (code)
      CODE_B8ZS: depth = IDX_W'(B8ZS_RUN);
      CODE_HDB3: depth = IDX_W'(HDB3_RUN);
      default:   depth = IDX_W'(AMI_DEPTH);
    endcase
  end

  assign sym_out = win[depth - 1'b1];

  // Window as it will stand after this strobe, before any replacement
  generate
    for (genvar j = 0; j < MAX_D; j++) begin : g_cand
      if (j == 0) begin : g_new
        assign cand[j] = sym_in;
      end else begin : g_old
        assign cand[j] = win[j-1];
      end
    end
  endgenerate

  always_comb begin
    run_zero = 1'b1;
    for (int j = 0; j < MAX_D; j++) begin
      if (j < int'(depth) && cand[j] != SYM_SPACE) run_zero = 1'b0;
    end
  end

  // Only bits sampled after reset may form a run
  assign run_real = ({1'b0, fill} + 1'b1) >= {1'b0, depth};
  assign sub_b8   = (code == CODE_B8ZS) && run_zero && run_real;
  assign sub_hd   = (code == CODE_HDB3) && run_zero && run_real;

  always_comb begin
    for (int j = 0; j < MAX_D; j++) begin
      nxt[j] = cand[j];
      if (sub_b8 && j < B8ZS_RUN) nxt[j] = b8zs_slot(j);
      if (sub_hd) begin
        if (j == 0)                          nxt[j] = SYM_VIOL;
        else if (j == HDB3_RUN-1 && !hdb3_odd) nxt[j] = SYM_MARK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      for (int j = 0; j < MAX_D; j++) win[j] <= SYM_SPACE;
    end else if (bit_en) begin
      if (fill != IDX_W'(MAX_D)) fill <= fill + 1'b1;
      for (int j = 0; j < MAX_D; j++) win[j] <= nxt[j];
    end
  end

  // R3: an eight-zero replacement leaves a violation in the newest-but-one slot
  a_r3_b8_slot: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sub_b8) |=> (win[1] == SYM_VIOL && win[0] == SYM_MARK));

  // R5: no run is replaced before the window holds only post-reset bits
  a_r5_fill_gate: assert property (@(posedge clk) disable iff (rst)
    (bit_en && fill == '0 && depth > 1) |=> (win[0] != SYM_VIOL));

endmodule

// File: rtl/t1e1_pulse_drive.sv
module t1e1_pulse_drive
  import t1e1_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_en,
  input  code_e code,
  input  sym_e  sym,
  output logic  hdb3_odd,
  output logic  tip,
  output logic  ring
);

  logic last_pos;   // polarity of the most recent coded pulse
  logic odd_cnt;    // B pulses since last V, modulo 2

  // Parity as it stands once the outgoing symbol has been sent
  always_comb begin
    if (sym == SYM_VIOL)      hdb3_odd = 1'b0;
    else if (sym == SYM_MARK) hdb3_odd = ~odd_cnt;
    else                      hdb3_odd = odd_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tip      <= 1'b0;
      ring     <= 1'b0;
      last_pos <= 1'b0;
      odd_cnt  <= 1'b0;
    end else if (bit_en) begin
      odd_cnt <= hdb3_odd;
      unique case (sym)
        SYM_MARK: begin
          tip      <= ~last_pos;
          ring     <= last_pos;
          last_pos <= ~last_pos;
        end
        SYM_VIOL: begin
          tip  <= last_pos;
          ring <= ~last_pos;
        end
        SYM_FIX_POS: begin
          tip  <= 1'b1;
          ring <= 1'b0;
        end
        SYM_FIX_NEG: begin
          tip  <= 1'b0;
          ring <= 1'b1;
        end
        default: begin
          tip  <= 1'b0;
          ring <= 1'b0;
        end
      endcase
    end
  end

  // Checker state observed at the output pins
  logic en_q, viol_q, mk_seen, mk_prev, v_seen, v_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; viol_q <= 1'b0;
      mk_seen <= 1'b0; mk_prev <= 1'b0;
      v_seen <= 1'b0; v_prev <= 1'b0;
    end else begin
      en_q   <= bit_en;
      viol_q <= bit_en && sym == SYM_VIOL;
      if (en_q && (tip || ring)) begin
        mk_seen <= 1'b1;
        mk_prev <= tip;
      end
      if (en_q && viol_q) begin
        v_seen <= 1'b1;
        v_prev <= tip;
      end
    end
  end

  a_r2_one_rail: assert property (@(posedge clk) disable iff (rst) !(tip && ring));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(tip) && $stable(ring)));

  a_r8_reset_low: assert property (@(posedge clk) rst |=> (!tip && !ring));

  a_r1_ami_alt: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_AMI && en_q && (tip || ring) && mk_seen) |-> (tip != mk_prev));

  a_r1_first_pos: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_AMI && en_q && (tip || ring) && !mk_seen) |-> tip);

  a_r4_v_alt: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_HDB3 && en_q && viol_q && v_seen) |-> (tip != v_prev));

endmodule

// File: rtl/t1e1_tx_encoder.sv
module t1e1_tx_encoder
  import t1e1_tx_pkg::*;
#(
  parameter int AMI_DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic dual_rail,
  input  logic zs_en,
  input  logic rate_cept,
  input  logic nrz_data,
  input  logic pos_data,
  input  logic neg_data,
  output logic tip_pulse,
  output logic ring_pulse
);

  localparam int MAX_D = (AMI_DEPTH > B8ZS_RUN) ? AMI_DEPTH : B8ZS_RUN;

  code_e code;
  sym_e  sym_in;
  sym_e  sym_out;
  logic  hdb3_odd;

  assign code = pick_code(dual_rail, zs_en, rate_cept);

  t1e1_sym_map u_map (
    .dual_rail (dual_rail),
    .nrz_data  (nrz_data),
    .pos_data  (pos_data),
    .neg_data  (neg_data),
    .sym       (sym_in)
  );

  t1e1_zs_window #(
    .MAX_D     (MAX_D),
    .AMI_DEPTH (AMI_DEPTH)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .code     (code),
    .sym_in   (sym_in),
    .hdb3_odd (hdb3_odd),
    .sym_out  (sym_out)
  );

  t1e1_pulse_drive u_drv (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .code     (code),
    .sym      (sym_out),
    .hdb3_odd (hdb3_odd),
    .tip      (tip_pulse),
    .ring     (ring_pulse)
  );

endmodule

// File: tb/t1e1_tx_encoder_tb_top.sv
module t1e1_tx_encoder_tb_top;

  localparam int NMAX = 2400;
  localparam int AMI_L = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic dual_rail = 1'b0, zs_en = 1'b0, rate_cept = 1'b0;
  logic nrz_data = 1'b0, pos_data = 1'b0, neg_data = 1'b0;
  logic tip_pulse, ring_pulse;

  always #10 clk = ~clk;   // 50 MHz

  t1e1_tx_encoder dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .dual_rail(dual_rail),
    .zs_en(zs_en), .rate_cept(rate_cept), .nrz_data(nrz_data),
    .pos_data(pos_data), .neg_data(neg_data),
    .tip_pulse(tip_pulse), .ring_pulse(ring_pulse)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_bits;
  logic in_a [NMAX];
  logic in_b [NMAX];
  logic ex_t [NMAX];
  logic ex_r [NMAX];
  int   sym  [NMAX];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got running expected finished");
    summary();
    $finish;
  end

  task automatic check(input string req, input int idx, input logic et, input logic er);
    n_cmp++;
    if (tip_pulse !== et || ring_pulse !== er) begin
      n_bad++;
      $display("FAIL %s bit %0d: got tip=%0b ring=%0b expected tip=%0b ring=%0b",
               req, idx, tip_pulse, ring_pulse, et, er);
    end
  endtask

  task automatic fill_single();
    n_bits = 0;
    for (int b = 0; b < 256; b++)
      for (int k = 0; k < 8; k++) begin in_a[n_bits] = ((b >> k) & 1) != 0; n_bits++; end
    for (int len = 1; len <= 12; len++) begin
      for (int k = 0; k < len; k++) begin in_a[n_bits] = 1'b0; n_bits++; end
      in_a[n_bits] = 1'b1; n_bits++;
    end
    for (int k = 0; k < 24; k++) begin in_a[n_bits] = 1'b0; n_bits++; end
  endtask

  task automatic fill_dual();
    n_bits = 0;
    for (int i = 0; i < 512; i++) begin
      in_a[n_bits] = (i & 1) != 0;
      in_b[n_bits] = (((i >> 1) ^ (i >> 3)) & 1) != 0;
      n_bits++;
    end
    for (int k = 0; k < 8; k++) begin in_a[n_bits] = 1'b0; in_b[n_bits] = 1'b0; n_bits++; end
  endtask

  // Expected symbols: 0 null, 1 B/mark, 2 violation; mode 0 plain, 1 eight-zero, 2 four-zero
  task automatic model_single(input int mode);
    int zrun, runlen;
    logic odd, last;
    zrun = 0; odd = 1'b0; last = 1'b0;
    runlen = (mode == 1) ? 8 : 4;
    for (int i = 0; i < n_bits; i++) begin
      if (in_a[i]) begin sym[i] = 1; zrun = 0; odd = ~odd; end
      else begin
        sym[i] = 0; zrun++;
        if (mode != 0 && zrun == runlen) begin
          if (mode == 1) begin
            sym[i-7] = 0; sym[i-6] = 0; sym[i-5] = 0; sym[i-4] = 2;
            sym[i-3] = 1; sym[i-2] = 0; sym[i-1] = 2; sym[i] = 1;
          end else begin
            sym[i-3] = odd ? 0 : 1; sym[i] = 2; odd = 1'b0;
          end
          zrun = 0;
        end
      end
    end
    for (int i = 0; i < n_bits; i++) begin
      if (sym[i] == 1) begin last = ~last; ex_t[i] = last; ex_r[i] = ~last; end
      else if (sym[i] == 2) begin ex_t[i] = last; ex_r[i] = ~last; end
      else begin ex_t[i] = 1'b0; ex_r[i] = 1'b0; end
    end
  endtask

  task automatic model_dual();
    for (int i = 0; i < n_bits; i++) begin
      ex_t[i] = in_a[i] && !in_b[i];
      ex_r[i] = in_b[i] && !in_a[i];
    end
  endtask

  task automatic do_reset(input logic d, input logic z, input logic c);
    rst = 1'b1; bit_en = 1'b0;
    dual_rail = d; zs_en = z; rate_cept = c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset", -1, 1'b0, 1'b0);
  endtask

  task automatic run_stream(input string req, input int lat, input int gap);
    for (int e = 0; e < n_bits; e++) begin
      nrz_data = in_a[e]; pos_data = in_a[e]; neg_data = in_b[e];
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (e >= lat) check(req, e - lat, ex_t[e-lat], ex_r[e-lat]);
      else          check({req, " R5 prefill"}, e, 1'b0, 1'b0);
      n_cmp++;
      if (tip_pulse && ring_pulse) begin
        n_bad++;
        $display("FAIL R2 bit %0d: got tip=1 ring=1 expected at most one high", e);
      end
      for (int g = 0; g < gap; g++) begin
        nrz_data = ~nrz_data; pos_data = ~pos_data; neg_data = ~neg_data;
        @(negedge clk);
        if (e >= lat) check("R7 hold", e - lat, ex_t[e-lat], ex_r[e-lat]);
        else          check("R7 hold", e, 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    // R1 plain alternate mark inversion (also R2 nulls, R5 latency)
    fill_single(); model_single(0);
    do_reset(1'b0, 1'b0, 1'b0);
    run_stream("R1,R5", AMI_L, 0);

    // R3 eight-zero substitution, latency 8
    model_single(1);
    do_reset(1'b0, 1'b1, 1'b0);
    run_stream("R3,R5", 8, 1);

    // R4 four-zero substitution, latency 4
    model_single(2);
    do_reset(1'b0, 1'b1, 1'b1);
    run_stream("R4,R5", 4, 2);

    // R9 substitution off at the higher rate
    model_single(0);
    do_reset(1'b0, 1'b0, 1'b1);
    run_stream("R9", AMI_L, 0);

    // R6 dual-rail bypass, coding pins set but ignored
    fill_dual(); model_dual();
    do_reset(1'b1, 1'b1, 1'b1);
    run_stream("R6,R5", AMI_L, 1);

    // R8 mid-stream reset empties the window and restores positive-first
    for (int i = 0; i < 6; i++) in_a[i] = 1'b1;
    n_bits = 6;
    model_single(0);
    do_reset(1'b0, 1'b0, 1'b0);
    run_stream("R8 preload", AMI_L, 0);
    in_a[0] = 1'b1;
    for (int i = 1; i < 6; i++) in_a[i] = 1'b0;
    n_bits = 6;
    model_single(0);
    do_reset(1'b0, 1'b0, 1'b0);
    run_stream("R8 restart", AMI_L, 0);

    summary();
    $finish;
  end

endmodule